// File: doc/BRIEF.md
# Byte-Wide Converter Readout Sequencer

This block runs one complete acquisition on an external 12-bit successive-approximation converter whose result bus is only eight bits wide. A pulse on `start` drives the converter's read/convert line low to begin a full-length conversion. The block then leaves the status line alone for its guaranteed rise time and polls it until it falls. It reads the result as two bytes, selected through the address line, and delivers the reassembled 12-bit word on a valid/ready output.

Every analogue timing limit is given in picoseconds and turned into clock cycles from the clock-period parameter, always rounded up. These limits are the minimum convert pulse, the latest status rise and the data access time. Status is synchronised before it is used. A conversion whose status stays high for too long ends with a timeout flag instead of a result.

The output follows the usual stream rules. `res_valid` rises when the word is ready. The word and the valid stay fixed until a cycle in which `res_ready` is high. The sequencer stays busy until that handshake, so back-pressure only stretches the current transaction and no result is ever lost or overwritten. With `res_ready` tied high, `res_valid` is a one-cycle pulse.

Top module: `conv_readout_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start is taken, `cnv_rc_n`=1, `cnv_cs_n`=1, `cnv_ce`=0, `cnv_a0`=0, `busy`=0, `res_valid`=0 and `timeout`=0.
- R2: A `start` seen high while idle drives `cnv_rc_n` low, with `cnv_cs_n`=0, `cnv_ce`=1 and `cnv_a0`=0 (full-length conversion), for exactly ceil(START_MIN_PS/CLK_PERIOD_PS) cycles (7 at 8 ns). After that, all four lines return to their released levels.
- R3: After the convert pulse, the lines stay released and status is ignored for ceil(STS_RISE_PS/CLK_PERIOD_PS) cycles (25 at 8 ns). Polling begins only after that.
- R4: Status passes through a SYNC_STAGES-flop synchroniser (2 by default). The first byte access starts in the cycle after the synchronised status is seen low while polling.
- R5: Each byte access holds `cnv_cs_n`=0, `cnv_ce`=1 and `cnv_rc_n`=1 for ceil(ACCESS_PS/CLK_PERIOD_PS) cycles (19 at 8 ns), and the byte is captured at the end of the access. The first access uses `cnv_a0`=0 (upper eight bits). One released cycle follows. The second access then uses `cnv_a0`=1 (lower four bits in byte bits 7:4).
- R6: `res_data` = {first byte, second byte[7:4]}, so bits 3:0 of the second byte have no effect. `res_valid` and `res_data` stay fixed until a cycle with `res_ready` high.
- R7: `start` has no effect while `busy` is high, including the cycle of the output handshake.
- R8: If the synchronised status is still high in the TIMEOUT_CYC-th polling cycle, the block returns to idle with `timeout`=1 and produces no result. `timeout` clears when the next start is taken.
- R9: If the synchronised status is first seen low in the last allowed polling cycle, the read goes ahead, the result is delivered and `timeout` stays 0.
- R10: `busy` is high from the cycle after a start is taken until the cycle after the output handshake or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one acquisition (taken only when idle) |
| busy | output | 1 | Transaction in progress |
| timeout | output | 1 | Last transaction saw no end of conversion |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | RES_W | Reassembled conversion result |
| cnv_rc_n | output | 1 | Converter read/convert line (low = convert) |
| cnv_cs_n | output | 1 | Converter chip select, active low |
| cnv_ce | output | 1 | Converter chip enable, active high |
| cnv_a0 | output | 1 | Converter byte/length select |
| cnv_sts | input | 1 | Converter status, high while converting |
| cnv_data | input | BYTE_W | Converter result byte |

## Verification
Two events can fall in the same cycle: the synchronised status dropping, and the poll watchdog reaching its limit. The converter model's conversion length is set so that status is first seen low in exactly the last allowed polling cycle. A second run uses one cycle more. The first run must deliver its word with the flag clear, and the second must raise the flag and deliver nothing. A start held high through the output handshake cycle, and a result held under back-pressure, are judged in the same way against a behavioural per-cycle model.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_ARM,
    ST_POLL,
    ST_RD_HI,
    ST_GAP,
    ST_RD_LO,
    ST_OUT
  } seq_state_t;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int unsigned span_cycles(input int unsigned dur_ps,
                                              input int unsigned period_ps);
    int unsigned c;
    c = (dur_ps + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_of3(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/conv_sts_sync.sv
module conv_sts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/conv_dwell_timer.sv
module conv_dwell_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: a running dwell never stalls or climbs without a reload.
  p_dwell_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/conv_word_pack.sv
module conv_word_pack #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_hi,
  input  logic              take_lo,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [RES_W-1:0]  word
);

  localparam int unsigned LO_W = RES_W - BYTE_W;

  logic [BYTE_W-1:0] hi_q;
  logic [LO_W-1:0]   lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (take_hi) hi_q <= byte_in;
      if (take_lo) lo_q <= byte_in[BYTE_W-1 -: LO_W];
    end
  end

  assign word = {hi_q, lo_q};

  // R5: the two byte captures are separate accesses.
  p_single_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_hi && take_lo));

  // R6: the assembled word only moves on a capture.
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_hi && !take_lo) |=> $stable(word));

endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq
  import conv_readout_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned START_MIN_PS  = 50000,
  parameter int unsigned STS_RISE_PS   = 200000,
  parameter int unsigned ACCESS_PS     = 150000,
  parameter int unsigned TIMEOUT_CYC   = 4096,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned BYTE_W        = 8,
  parameter int unsigned RES_W         = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              timeout,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data,
  output logic              cnv_rc_n,
  output logic              cnv_cs_n,
  output logic              cnv_ce,
  output logic              cnv_a0,
  input  logic              cnv_sts,
  input  logic [BYTE_W-1:0] cnv_data
);

  localparam int unsigned START_CYC = span_cycles(START_MIN_PS, CLK_PERIOD_PS);
  localparam int unsigned RISE_CYC  = span_cycles(STS_RISE_PS, CLK_PERIOD_PS);
  localparam int unsigned ACC_CYC   = span_cycles(ACCESS_PS, CLK_PERIOD_PS);
  localparam int unsigned DW_MAX    = max_of3(START_CYC, RISE_CYC, ACC_CYC);
  localparam int unsigned DW_W      = $clog2(DW_MAX + 1);
  localparam int unsigned WD_W      = $clog2(TIMEOUT_CYC + 1);

  localparam logic [DW_W-1:0] LD_PULSE = DW_W'(START_CYC - 1);
  localparam logic [DW_W-1:0] LD_RISE  = DW_W'(RISE_CYC - 1);
  localparam logic [DW_W-1:0] LD_ACC   = DW_W'(ACC_CYC - 1);
  localparam logic [WD_W-1:0] LD_WDOG  = WD_W'(TIMEOUT_CYC - 1);

  seq_state_t state_q, state_d;

  logic            sts_s;
  logic            dwell_ld, dwell_done;
  logic [DW_W-1:0] dwell_val;
  logic            wdog_ld, wdog_done;
  logic            take_hi, take_lo;
  logic            to_set, to_clr;
  logic            timeout_q;
  logic [RES_W-1:0] word;

  conv_sts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cnv_sts),
    .q     (sts_s)
  );

  conv_dwell_timer #(.W(DW_W)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dwell_ld),
    .load_val (dwell_val),
    .expired  (dwell_done)
  );

  conv_dwell_timer #(.W(WD_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wdog_ld),
    .load_val (LD_WDOG),
    .expired  (wdog_done)
  );

  conv_word_pack #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_hi (take_hi),
    .take_lo (take_lo),
    .byte_in (cnv_data),
    .word    (word)
  );

  // Sequencing: each dwell state is entered with its count loaded.
  always_comb begin
    state_d   = state_q;
    dwell_ld  = 1'b0;
    dwell_val = '0;
    wdog_ld   = 1'b0;
    take_hi   = 1'b0;
    take_lo   = 1'b0;
    to_set    = 1'b0;
    to_clr    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_PULSE;
          dwell_ld  = 1'b1;
          dwell_val = LD_PULSE;
          to_clr    = 1'b1;
        end
      end
      ST_PULSE: begin
        if (dwell_done) begin
          state_d   = ST_ARM;
          dwell_ld  = 1'b1;
          dwell_val = LD_RISE;
        end
      end
      ST_ARM: begin
        if (dwell_done) begin
          state_d = ST_POLL;
          wdog_ld = 1'b1;
        end
      end
      ST_POLL: begin
        // End of conversion outranks an expiring watchdog.
        if (!sts_s) begin
          state_d   = ST_RD_HI;
          dwell_ld  = 1'b1;
          dwell_val = LD_ACC;
        end else if (wdog_done) begin
          state_d = ST_IDLE;
          to_set  = 1'b1;
        end
      end
      ST_RD_HI: begin
        if (dwell_done) begin
          state_d = ST_GAP;
          take_hi = 1'b1;
        end
      end
      ST_GAP: begin
        state_d   = ST_RD_LO;
        dwell_ld  = 1'b1;
        dwell_val = LD_ACC;
      end
      ST_RD_LO: begin
        if (dwell_done) begin
          state_d = ST_OUT;
          take_lo = 1'b1;
        end
      end
      ST_OUT: begin
        if (res_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (to_set)      timeout_q <= 1'b1;
      else if (to_clr) timeout_q <= 1'b0;
    end
  end

  // Converter pin decode, released levels by default.
  always_comb begin
    cnv_rc_n = 1'b1;
    cnv_cs_n = 1'b1;
    cnv_ce   = 1'b0;
    cnv_a0   = 1'b0;
    unique case (state_q)
      ST_PULSE: begin
        cnv_rc_n = 1'b0;
        cnv_cs_n = 1'b0;
        cnv_ce   = 1'b1;
      end
      ST_RD_HI: begin
        cnv_cs_n = 1'b0;
        cnv_ce   = 1'b1;
      end
      ST_RD_LO: begin
        cnv_cs_n = 1'b0;
        cnv_ce   = 1'b1;
        cnv_a0   = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy      = (state_q != ST_IDLE);
  assign res_valid = (state_q == ST_OUT);
  assign res_data  = word;
  assign timeout   = timeout_q;

  // Observation counters used only by the properties below.
  localparam int unsigned LR_W = $clog2(START_CYC + 2) + 1;
  localparam int unsigned AA_W = $clog2(RISE_CYC + 2) + 1;
  localparam logic [AA_W-1:0] AGE_CAP = AA_W'(RISE_CYC + 1);

  logic [LR_W-1:0] low_run_q;
  logic [AA_W-1:0] arm_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      arm_age_q <= AGE_CAP;
    end else begin
      low_run_q <= cnv_rc_n ? '0 : low_run_q + 1'b1;
      if (!cnv_rc_n)               arm_age_q <= '0;
      else if (arm_age_q != AGE_CAP) arm_age_q <= arm_age_q + 1'b1;
    end
  end

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_rc_n) |-> (low_run_q == LR_W'(START_CYC)));

  p_full_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_rc_n |-> (!cnv_a0 && !cnv_cs_n && cnv_ce));

  p_rise_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cnv_ce) && cnv_rc_n) |-> (arm_age_q >= AA_W'(RISE_CYC)));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$fell(cnv_rc_n));

  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!res_valid && !busy));

endmodule

// File: tb/conv_readout_seq_tb_top.sv
`timescale 1ns/1ps
module conv_readout_seq_tb_top;

  localparam int unsigned PER_PS = 8000;
  localparam int unsigned TO     = 64;
  localparam int unsigned BW     = 8;
  localparam int unsigned RW     = 12;
  localparam int unsigned START_CYC = (50000  + PER_PS - 1) / PER_PS;
  localparam int unsigned RISE_CYC  = (200000 + PER_PS - 1) / PER_PS;
  localparam int unsigned ACC_CYC   = (150000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic res_ready = 1'b1;
  logic busy, timeout, res_valid;
  logic [RW-1:0] res_data;
  logic rc_n, cs_n, ce, a0;
  logic m_sts = 1'b0;
  logic [BW-1:0] m_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  conv_readout_seq #(
    .CLK_PERIOD_PS(PER_PS), .TIMEOUT_CYC(TO), .BYTE_W(BW), .RES_W(RW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .timeout(timeout),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .cnv_rc_n(rc_n), .cnv_cs_n(cs_n), .cnv_ce(ce), .cnv_a0(a0),
    .cnv_sts(m_sts), .cnv_data(m_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Behavioural converter: status rise/fall after set delays, bytes valid late.
  int rise_dly = 22;
  int conv_len = 40;
  logic [RW-1:0] next_sample = '0;
  logic [RW-1:0] conv_val = '0;
  logic [3:0] pad = 4'h0;
  bit conv_active = 0;
  int mcnt = 0;
  bit prev_rc = 1;
  bit prev_a0 = 0;
  bit rd_on = 0;
  int rd_cnt = 0;

  always @(negedge clk) begin
    logic [BW-1:0] good;
    if (!rst_n) begin
      m_sts = 1'b0; conv_active = 0; prev_rc = 1; rd_on = 0; rd_cnt = 0;
      m_data = '0;
    end else begin
      if (conv_active) begin
        mcnt++;
        if (mcnt == rise_dly) m_sts = 1'b1;
        if (mcnt == rise_dly + conv_len) begin
          m_sts = 1'b0;
          conv_active = 0;
        end
      end else if (prev_rc && !rc_n && !cs_n && ce) begin
        conv_active = 1;
        mcnt = 0;
        conv_val = next_sample;
      end
      prev_rc = rc_n;
      if (!cs_n && ce && rc_n && !m_sts && !conv_active) begin
        if (!rd_on || a0 != prev_a0) rd_cnt = 1;
        else rd_cnt++;
        rd_on = 1;
        good = a0 ? {conv_val[3:0], pad} : conv_val[11:4];
        m_data = (rd_cnt >= 17) ? good : ~good;
      end else begin
        rd_on = 0;
        m_data = 8'h00;
      end
      prev_a0 = a0;
    end
  end

  // Per-cycle reference of the expected pin and output levels.
  bit ref_on = 0;
  bit s_start, s_ready, h1 = 0, h2 = 0;
  bit exp_rc = 1, exp_cs = 1, exp_ce = 0, exp_a0 = 0;
  bit exp_busy = 0, exp_valid = 0, exp_to = 0;
  logic [RW-1:0] exp_data = '0;

  task automatic tick();
    @(posedge clk);
    s_start = start;
    s_ready = res_ready;
    h2 = h1;
    h1 = m_sts;
  endtask

  task automatic pins(input bit r, input bit c, input bit e, input bit a);
    exp_rc = r; exp_cs = c; exp_ce = e; exp_a0 = a;
  endtask

  initial begin
    bit got;
    wait (rst_n === 1'b1);
    ref_on = 1;
    forever begin
      pins(1, 1, 0, 0);
      exp_busy = 0;
      exp_valid = 0;
      do tick(); while (!s_start);
      exp_to = 0;
      exp_busy = 1;
      pins(0, 0, 1, 0);
      repeat (START_CYC) tick();
      pins(1, 1, 0, 0);
      repeat (RISE_CYC) tick();
      got = 0;
      for (int t = 0; t < TO; t++) begin
        if (!h2) begin
          got = 1;
          tick();
          break;
        end
        tick();
      end
      if (!got) begin
        exp_to = 1;
        continue;
      end
      pins(1, 0, 1, 0);
      repeat (ACC_CYC) tick();
      pins(1, 1, 0, 0);
      tick();
      pins(1, 0, 1, 1);
      repeat (ACC_CYC) tick();
      pins(1, 1, 0, 0);
      exp_valid = 1;
      exp_data = conv_val;
      do tick(); while (!s_ready);
    end
  end

  always @(negedge clk) begin
    if (rst_n && ref_on) begin
      chk(rc_n == exp_rc, "R2", "cnv_rc_n", rc_n, exp_rc);
      chk(ce == exp_ce, "R3", "cnv_ce", ce, exp_ce);
      chk(cs_n == exp_cs, "R4", "cnv_cs_n", cs_n, exp_cs);
      chk(a0 == exp_a0, "R5", "cnv_a0", a0, exp_a0);
      chk(busy == exp_busy, "R10", "busy", busy, exp_busy);
      chk(res_valid == exp_valid, "R6", "res_valid", res_valid, exp_valid);
      if (exp_valid)
        chk(res_data == exp_data, "R6", "res_data", res_data, exp_data);
      chk(timeout == exp_to, "R8", "timeout", timeout, exp_to);
    end
  end

  // Accepted results.
  logic [RW-1:0] got_q[$];
  always @(posedge clk) begin
    if (rst_n && res_valid && res_ready) got_q.push_back(res_data);
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below %0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_txn(input logic [RW-1:0] s, input int rd, input int cl,
                         input logic [3:0] pv);
    @(negedge clk);
    next_sample = s; rise_dly = rd; conv_len = cl; pad = pv;
    pulse_start();
    wait_idle();
  endtask

  task automatic expect_one(input logic [RW-1:0] s, input string req);
    chk(got_q.size() == 1, req, "result count", got_q.size(), 1);
    if (got_q.size() > 0) begin
      logic [RW-1:0] v;
      v = got_q.pop_front();
      chk(v == s, req, "result word", v, s);
    end
    got_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(rc_n == 1 && cs_n == 1, "R1", "rc_n,cs_n in reset", {rc_n, cs_n}, 2'b11);
    chk(ce == 0 && a0 == 0, "R1", "ce,a0 in reset", {ce, a0}, 0);
    chk(!busy && !res_valid && !timeout, "R1", "busy,valid,timeout in reset",
        {busy, res_valid, timeout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && rc_n, "R1", "idle after reset", {busy, rc_n}, 2'b01);

    run_txn(12'hA5C, 22, 40, 4'h0);
    expect_one(12'hA5C, "R6");
    run_txn(12'h000, 22, 10, 4'h0);
    expect_one(12'h000, "R6");
    run_txn(12'hFFF, 22, 55, 4'h0);
    expect_one(12'hFFF, "R6");
    // R6: padding nibble of the second byte is discarded
    run_txn(12'h3C7, 22, 30, 4'hF);
    expect_one(12'h3C7, "R6");

    // R7: starts during a transaction are dropped
    @(negedge clk);
    next_sample = 12'h5E1; rise_dly = 22; conv_len = 20; pad = 4'h0;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (5) @(negedge clk);
    chk(!busy, "R7", "busy after ignored starts", busy, 0);
    expect_one(12'h5E1, "R7");

    // R6 back-pressure, R7 start in handshake cycle
    @(negedge clk);
    res_ready = 1'b0;
    next_sample = 12'h71B;
    pulse_start();
    while (!res_valid) @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      chk(res_valid && res_data == 12'h71B, "R6", "held word",
          res_data, 12'h71B);
    end
    res_ready = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R7", "busy after handshake-cycle start", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && rc_n, "R7", "no new conversion", {busy, rc_n}, 2'b01);
    expect_one(12'h71B, "R6");

    // R8: status seen one cycle too late
    run_txn(12'h123, 22, TO + 30 - 22, 4'h0);
    chk(timeout == 1, "R8", "timeout flag", timeout, 1);
    chk(got_q.size() == 0, "R8", "no result on timeout", got_q.size(), 0);
    repeat (20) @(negedge clk);

    // R9: status seen in the last allowed cycle; R8 flag clears on start
    @(negedge clk);
    next_sample = 12'h9E1; rise_dly = 22; conv_len = TO + 29 - 22;
    pulse_start();
    chk(timeout == 0, "R8", "timeout cleared by start", timeout, 0);
    wait_idle();
    chk(timeout == 0, "R9", "no timeout at limit", timeout, 0);
    expect_one(12'h9E1, "R9");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule